// File: doc/BRIEF.md
# Single-Wire Slave Command Sequencer

This block is the slave end of a single-wire, open-drain sensor bus. It samples the shared line and pulls it low when it needs to signal. It recognises bus reset pulses and answers each one with a presence pulse. Write slots become bytes, received least significant bit first, and the block drives read slots when it has data to send. On top of that bit layer sits a two-level sequencer. The ROM-level command comes first. The function-level command follows. Traffic that breaks this order is ignored until the next bus reset.

The identity answered by the ROM level is fixed at elaboration. It is a 64-bit code made from a family byte, a 48-bit serial number parameter and a CRC computed over the first 56 bits. The function level reaches a scratchpad through a narrow read port and a byte-write port. Conversion, copy and recall are started with single-cycle pulses, and their progress comes back through busy inputs. All bus timing is counted in clock cycles from the parameter `CYC_PER_US`, the number of clocks in one microsecond.

Top module: `ow_slave_seq`

## Requirements
- R1: After the line has been low for at least 480 µs and is released, the block pulls the line low for 120 µs, starting 30 µs after it sees the line high. It does not pull at any other time in that window.
- R2: Out of power-on reset the block keeps the line released and ignores all slots until a bus reset arrives. Any low of 480 µs or more, in any state, aborts the current transaction and begins a new one.
- R3: A write slot is sampled 30 µs after its falling edge, and received bytes are assembled least significant bit first.
- R4: In a read slot that carries 0, the block holds the line low from the falling edge until 30 µs after it. A read slot that carries 1 is left released.
- R5: ROM opcode 33h sends the 64-bit identity LSB first: family byte 28h, then the serial number, then CRC-8 (polynomial x^8+x^5+x^4+1, initial value 0, shifted LSB first over the first 56 bits).
- R6: ROM opcode 55h compares the next 64 written bits with the identity. A full match moves to the function level. On any mismatch the block stays silent (every read slot returns 1) until the next bus reset.
- R7: ROM opcode CCh moves straight to the function level. Opcodes F0h and ECh, and any other ROM-level byte, make the block silent until the next bus reset.
- R8: A function opcode not in the set 44h, 4Eh, BEh, 48h, B8h, B4h makes the block silent and raises no start pulse.
- R9: Function BEh sends scratchpad bytes 0 through 8, each LSB first, with `sp_rd_idx_o` giving the byte index. After byte 8 the block is silent. A bus reset may cut the read short at any point.
- R10: Function 4Eh takes exactly three bytes and writes them, in arrival order, to write index 0, 1 and 2 with one `sp_wr_en_o` pulse each. Further bytes have no effect.
- R11: Function 44h raises `conv_start_o` for one cycle. Each following read slot returns 0 while `conv_busy_i` is high and 1 once it is low.
- R12: Function B8h raises `recall_start_o` for one cycle. Each following read slot returns 0 while `recall_busy_i` is high and 1 once it is low.
- R13: Function 48h raises `copy_start_o` for one cycle and then goes silent. Function B4h answers one read slot with 0 if `parasite_i` is high and with 1 otherwise, and then goes silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the shared bus line |
| line_pull_o | output | 1 | High pulls the bus line low |
| parasite_i | input | 1 | High when the device draws power from the line |
| conv_busy_i | input | 1 | Conversion in progress |
| recall_busy_i | input | 1 | Recall in progress |
| conv_start_o | output | 1 | One-cycle conversion start |
| copy_start_o | output | 1 | One-cycle copy start |
| recall_start_o | output | 1 | One-cycle recall start |
| sp_rd_idx_o | output | 4 | Scratchpad byte index being read |
| sp_rd_data_i | input | 8 | Scratchpad byte at `sp_rd_idx_o` |
| sp_wr_en_o | output | 1 | Scratchpad write strobe |
| sp_wr_idx_o | output | 2 | Write index: 0, 1 or 2 |
| sp_wr_data_o | output | 8 | Byte to write |

## Verification
The bench builds the block with `CYC_PER_US` set to 2 and a non-default serial number. Each microsecond therefore costs two clocks. A 480 µs reset then takes under a thousand cycles, so the run has room for complete transactions: a full identity read, a Match ROM followed by all nine scratchpad bytes, and deliberate aborts. The chosen serial number produces a CRC byte with mixed bits, so the check on the last identity byte does real work. Two clocks per microsecond also leave a little slack between the synchroniser delay and the slot sample points the bench uses.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;

  localparam logic [7:0] FAMILY_CODE = 8'h28;

  // ROM-level opcodes
  localparam logic [7:0] ROM_READ   = 8'h33;
  localparam logic [7:0] ROM_MATCH  = 8'h55;
  localparam logic [7:0] ROM_SKIP   = 8'hCC;
  localparam logic [7:0] ROM_SEARCH = 8'hF0;
  localparam logic [7:0] ROM_ALARM  = 8'hEC;

  // function-level opcodes
  localparam logic [7:0] FN_CONV    = 8'h44;
  localparam logic [7:0] FN_WRSP    = 8'h4E;
  localparam logic [7:0] FN_RDSP    = 8'hBE;
  localparam logic [7:0] FN_COPY    = 8'h48;
  localparam logic [7:0] FN_RECALL  = 8'hB8;
  localparam logic [7:0] FN_PWR     = 8'hB4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SLOT, PH_RSTLOW, PH_PWAIT, PH_PDRV
  } phy_st_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_ROM, SQ_MATCH, SQ_TXROM, SQ_FUNC,
    SQ_WRSP, SQ_RDSP, SQ_STAT, SQ_PWR
  } seq_st_t;

  // reflected CRC-8, x^8+x^5+x^4+1, LSB of data first, start value 0
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/ow_line_phy.sv
module ow_line_phy
  import ow_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic tx_en,
  input  logic tx_bit,
  output logic line_pull,
  output logic rst_evt,
  output logic slot_stb,
  output logic slot_bit
);

  localparam int RST_CYC = 480 * CYC_PER_US;
  localparam int PW_CYC  = 30 * CYC_PER_US;
  localparam int PD_CYC  = 120 * CYC_PER_US;
  localparam int SMP_CYC = 30 * CYC_PER_US;
  localparam int DRV_CYC = 30 * CYC_PER_US;
  localparam int CW      = $clog2(RST_CYC + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  phy_st_t       st_q, st_n;
  logic [CW-1:0] tcnt_q, tcnt_n;
  logic [CW-1:0] lcnt_q, lcnt_n;
  logic          drv0_q, drv0_n;
  logic          s, fall;

  assign s    = sync_q[1];
  assign fall = prev_q & ~s;

  // length of the current low, saturating
  always_comb begin
    if (s)                              lcnt_n = '0;
    else if (lcnt_q == CW'(RST_CYC))    lcnt_n = lcnt_q;
    else                                lcnt_n = lcnt_q + CW'(1);
  end

  assign rst_evt = ~s && (lcnt_q == CW'(RST_CYC - 1));

  always_comb begin
    st_n   = st_q;
    tcnt_n = tcnt_q;
    drv0_n = drv0_q;
    if (rst_evt) begin
      st_n   = PH_RSTLOW;
      tcnt_n = '0;
    end else begin
      case (st_q)
        PH_IDLE: if (fall) begin
          st_n   = PH_SLOT;
          tcnt_n = '0;
          drv0_n = tx_en & ~tx_bit;
        end
        PH_SLOT: begin
          if (tcnt_q != CW'(SMP_CYC)) tcnt_n = tcnt_q + CW'(1);
          else if (s)                 st_n   = PH_IDLE;
        end
        PH_RSTLOW: if (s) begin
          st_n   = PH_PWAIT;
          tcnt_n = '0;
        end
        PH_PWAIT: begin
          if (tcnt_q == CW'(PW_CYC - 1)) begin
            st_n   = PH_PDRV;
            tcnt_n = '0;
          end else tcnt_n = tcnt_q + CW'(1);
        end
        PH_PDRV: begin
          if (tcnt_q == CW'(PD_CYC - 1)) st_n = PH_IDLE;
          else                           tcnt_n = tcnt_q + CW'(1);
        end
        default: st_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      st_q   <= PH_IDLE;
      tcnt_q <= '0;
      lcnt_q <= '0;
      drv0_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      prev_q <= s;
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      lcnt_q <= lcnt_n;
      drv0_q <= drv0_n;
    end
  end

  assign slot_stb  = (st_q == PH_SLOT) && (tcnt_q == CW'(SMP_CYC - 1));
  assign slot_bit  = s;
  assign line_pull = (st_q == PH_PDRV) ||
                     ((st_q == PH_SLOT) && drv0_q && (tcnt_q < CW'(DRV_CYC)));

endmodule

// File: rtl/ow_cmd_seq.sv
module ow_cmd_seq
  import ow_seq_pkg::*;
#(
  parameter logic [63:0] ID_CODE = 64'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_evt,
  input  logic       slot_stb,
  input  logic       slot_bit,
  output logic       tx_en,
  output logic       tx_bit,
  input  logic       parasite,
  input  logic       conv_busy,
  input  logic       recall_busy,
  output logic [3:0] sp_rd_idx,
  input  logic [7:0] sp_rd_data,
  output logic       conv_start,
  output logic       copy_start,
  output logic       recall_start,
  output logic       sp_wr_en,
  output logic [1:0] sp_wr_idx,
  output logic [7:0] sp_wr_data
);

  localparam int CNTW = 7;

  seq_st_t         st_q, st_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [7:0]      sh_q, sh_n, shin;
  logic            rec_q, rec_n;
  logic            conv_n, copy_n, recs_n, wen_n;
  logic [1:0]      widx_n;
  logic [7:0]      wdat_n;
  logic            byte_end;

  assign shin     = {slot_bit, sh_q[7:1]};
  assign byte_end = (cnt_q[2:0] == 3'd7);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    rec_n  = rec_q;
    conv_n = 1'b0;
    copy_n = 1'b0;
    recs_n = 1'b0;
    wen_n  = 1'b0;
    widx_n = sp_wr_idx;
    wdat_n = sp_wr_data;
    if (rst_evt) begin
      st_n  = SQ_ROM;
      cnt_n = '0;
    end else if (slot_stb) begin
      cnt_n = cnt_q + CNTW'(1);
      case (st_q)
        SQ_ROM: begin
          sh_n = shin;
          if (byte_end) begin
            cnt_n = '0;
            case (shin)
              ROM_READ:              st_n = SQ_TXROM;
              ROM_MATCH:             st_n = SQ_MATCH;
              ROM_SKIP:              st_n = SQ_FUNC;
              ROM_SEARCH, ROM_ALARM: st_n = SQ_IDLE;
              default:               st_n = SQ_IDLE;
            endcase
          end
        end
        SQ_MATCH: begin
          if (slot_bit != ID_CODE[cnt_q[5:0]]) st_n = SQ_IDLE;
          else if (cnt_q == CNTW'(63)) begin
            st_n  = SQ_FUNC;
            cnt_n = '0;
          end
        end
        SQ_TXROM: if (cnt_q == CNTW'(63)) st_n = SQ_IDLE;
        SQ_FUNC: begin
          sh_n = shin;
          if (byte_end) begin
            cnt_n = '0;
            case (shin)
              FN_CONV:   begin conv_n = 1'b1; rec_n = 1'b0; st_n = SQ_STAT; end
              FN_RECALL: begin recs_n = 1'b1; rec_n = 1'b1; st_n = SQ_STAT; end
              FN_COPY:   begin copy_n = 1'b1; st_n = SQ_IDLE; end
              FN_WRSP:   st_n = SQ_WRSP;
              FN_RDSP:   st_n = SQ_RDSP;
              FN_PWR:    st_n = SQ_PWR;
              default:   st_n = SQ_IDLE;
            endcase
          end
        end
        SQ_WRSP: begin
          sh_n = shin;
          if (byte_end) begin
            wen_n  = 1'b1;
            widx_n = cnt_q[4:3];
            wdat_n = shin;
            if (cnt_q == CNTW'(23)) st_n = SQ_IDLE;
          end
        end
        SQ_RDSP: if (cnt_q == CNTW'(71)) st_n = SQ_IDLE;
        SQ_PWR:  st_n = SQ_IDLE;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SQ_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      rec_q        <= 1'b0;
      conv_start   <= 1'b0;
      copy_start   <= 1'b0;
      recall_start <= 1'b0;
      sp_wr_en     <= 1'b0;
      sp_wr_idx    <= '0;
      sp_wr_data   <= '0;
    end else begin
      st_q         <= st_n;
      cnt_q        <= cnt_n;
      sh_q         <= sh_n;
      rec_q        <= rec_n;
      conv_start   <= conv_n;
      copy_start   <= copy_n;
      recall_start <= recs_n;
      sp_wr_en     <= wen_n;
      sp_wr_idx    <= widx_n;
      sp_wr_data   <= wdat_n;
    end
  end

  assign sp_rd_idx = cnt_q[6:3];

  always_comb begin
    tx_en  = 1'b0;
    tx_bit = 1'b1;
    case (st_q)
      SQ_TXROM: begin tx_en = 1'b1; tx_bit = ID_CODE[cnt_q[5:0]];          end
      SQ_RDSP:  begin tx_en = 1'b1; tx_bit = sp_rd_data[cnt_q[2:0]];       end
      SQ_STAT:  begin tx_en = 1'b1; tx_bit = ~(rec_q ? recall_busy : conv_busy); end
      SQ_PWR:   begin tx_en = 1'b1; tx_bit = ~parasite;                    end
      default:  ;
    endcase
  end

endmodule

// File: rtl/ow_slave_seq.sv
module ow_slave_seq
  import ow_seq_pkg::*;
#(
  parameter int          CYC_PER_US = 50,
  parameter logic [47:0] SERIAL     = 48'h0000_0B2C_71E4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       line_pull_o,
  input  logic       parasite_i,
  input  logic       conv_busy_i,
  input  logic       recall_busy_i,
  output logic       conv_start_o,
  output logic       copy_start_o,
  output logic       recall_start_o,
  output logic [3:0] sp_rd_idx_o,
  input  logic [7:0] sp_rd_data_i,
  output logic       sp_wr_en_o,
  output logic [1:0] sp_wr_idx_o,
  output logic [7:0] sp_wr_data_o
);

  localparam logic [55:0] ID_LOW  = {SERIAL, FAMILY_CODE};
  localparam logic [63:0] ID_CODE = {crc8_lsb(ID_LOW), ID_LOW};

  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic       rst_evt, slot_stb, slot_bit, tx_en, tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  ow_line_phy #(.CYC_PER_US(CYC_PER_US)) u_phy (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_i    (line_i),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .line_pull (line_pull_o),
    .rst_evt   (rst_evt),
    .slot_stb  (slot_stb),
    .slot_bit  (slot_bit)
  );

  ow_cmd_seq #(.ID_CODE(ID_CODE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rst_evt      (rst_evt),
    .slot_stb     (slot_stb),
    .slot_bit     (slot_bit),
    .tx_en        (tx_en),
    .tx_bit       (tx_bit),
    .parasite     (parasite_i),
    .conv_busy    (conv_busy_i),
    .recall_busy  (recall_busy_i),
    .sp_rd_idx    (sp_rd_idx_o),
    .sp_rd_data   (sp_rd_data_i),
    .conv_start   (conv_start_o),
    .copy_start   (copy_start_o),
    .recall_start (recall_start_o),
    .sp_wr_en     (sp_wr_en_o),
    .sp_wr_idx    (sp_wr_idx_o),
    .sp_wr_data   (sp_wr_data_o)
  );

endmodule

// File: rtl/ow_slave_seq_chk.sv
module ow_slave_seq_chk #(
  parameter int CYC_PER_US = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_pull,
  input logic       rst_evt,
  input logic       slot_stb,
  input logic       conv_start,
  input logic       copy_start,
  input logic       recall_start,
  input logic       sp_wr_en,
  input logic [1:0] sp_wr_idx
);

  localparam int PD_CYC = 120 * CYC_PER_US;
  localparam int RW     = $clog2(PD_CYC + 2) + 1;

  logic [RW-1:0] pull_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pull_run <= '0;
    else if (!line_pull)                 pull_run <= '0;
    else if (pull_run != {RW{1'b1}})     pull_run <= pull_run + RW'(1);
  end

  p_pull_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pull_run <= RW'(PD_CYC));

  p_release_on_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !line_pull);

  p_slot_not_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_stb && rst_evt));

  p_wr_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (sp_wr_idx != 2'd3));

  p_wr_after_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> $past(slot_stb));

  p_starts_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, copy_start, recall_start}));

  p_conv_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_recall_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);

  p_copy_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start);

endmodule

bind ow_slave_seq ow_slave_seq_chk #(.CYC_PER_US(CYC_PER_US)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .line_pull    (line_pull_o),
  .rst_evt      (rst_evt),
  .slot_stb     (slot_stb),
  .conv_start   (conv_start_o),
  .copy_start   (copy_start_o),
  .recall_start (recall_start_o),
  .sp_wr_en     (sp_wr_en_o),
  .sp_wr_idx    (sp_wr_idx_o)
);

// File: tb/sim_ow_slave_seq.sv
`timescale 1ns/1ps
module sim_ow_slave_seq;

  localparam int          CPU    = 2;
  localparam logic [47:0] SERIAL = 48'h00A1_5C3E_9B27;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_low;
  logic       pull;
  logic       parasite, conv_busy, recall_busy;
  logic       conv_start, copy_start, recall_start;
  logic [3:0] rd_idx;
  logic [7:0] rd_data;
  logic       wr_en;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  wire        line = ~(m_low | pull);

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int n_conv = 0, n_copy = 0, n_recall = 0, n_wr = 0;
  logic [7:0] wr_log [4];
  logic [1:0] wr_ilog [4];
  logic       late_level;

  always #5 clk = ~clk;

  assign rd_data = 8'h41 + 8'({4'h0, rd_idx}) * 8'h1D;

  ow_slave_seq #(.CYC_PER_US(CPU), .SERIAL(SERIAL)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .line_pull_o(pull),
    .parasite_i(parasite), .conv_busy_i(conv_busy), .recall_busy_i(recall_busy),
    .conv_start_o(conv_start), .copy_start_o(copy_start), .recall_start_o(recall_start),
    .sp_rd_idx_o(rd_idx), .sp_rd_data_i(rd_data),
    .sp_wr_en_o(wr_en), .sp_wr_idx_o(wr_idx), .sp_wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    if (conv_start)   n_conv++;
    if (copy_start)   n_copy++;
    if (recall_start) n_recall++;
    if (wr_en) begin
      if (n_wr < 4) begin
        wr_log[n_wr]  = wr_data;
        wr_ilog[n_wr] = wr_idx;
      end
      n_wr++;
    end
  end

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic x;
      x = d[i] ^ c[0];
      c = {1'b0, c[7:1]};
      if (x) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  localparam logic [63:0] EXP_ID = {ref_crc({SERIAL, 8'h28}), SERIAL, 8'h28};

  function automatic logic [7:0] sp_byte(input int k);
    return 8'h41 + 8'(k) * 8'h1D;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic bus_reset(input bit check);
    m_low = 1'b1;
    wait_us(500);
    m_low = 1'b0;
    wait_us(10);
    if (check) chk("R1 no early presence", line, 1'b1);
    wait_us(70);
    if (check) chk("R1 presence low at 80us", line, 1'b0);
    wait_us(120);
    if (check) chk("R1 presence over at 200us", line, 1'b1);
    wait_us(50);
  endtask

  task automatic wr_bit(input logic b);
    m_low = 1'b1;
    if (b) begin wait_us(3);  m_low = 1'b0; wait_us(67); end
    else   begin wait_us(65); m_low = 1'b0; wait_us(5);  end
  endtask

  task automatic rd_bit(output logic b);
    m_low = 1'b1;
    wait_us(3);
    m_low = 1'b0;
    wait_us(12);
    b = line;
    wait_us(25);
    late_level = line;
    wait_us(30);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic rd_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic b;
      rd_bit(b);
      v[i] = b;
    end
  endtask

  // rom opcode, function opcode, expected {conv, copy, recall} pulses
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {8'hCC, 8'h44, 3'b100},
    {8'hCC, 8'h48, 3'b010},
    {8'hCC, 8'hB8, 3'b001},
    {8'h44, 8'h44, 3'b000},
    {8'hF0, 8'h44, 3'b000},
    {8'hEC, 8'h48, 3'b000},
    {8'hCC, 8'h5A, 3'b000}
  };

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       b;
    logic [7:0] by;
    logic [63:0] got;
    int c0, c1, c2;
    m_low = 1'b0; parasite = 1'b0; conv_busy = 1'b0; recall_busy = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 released in reset", pull, 1'b0);
    chk("R2 no start in reset", {conv_start, copy_start, recall_start}, 3'b000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // silent before any bus reset
    wr_byte(8'hCC); wr_byte(8'h44);
    rd_bit(b);
    chk("R2 silent before bus reset", b, 1'b1);
    chk("R2 no conversion before bus reset", n_conv, 0);

    // presence timing
    bus_reset(1'b1);

    // command table: R7 R8 R11 R12 R13
    for (int v = 0; v < NV; v++) begin
      c0 = n_conv; c1 = n_copy; c2 = n_recall;
      bus_reset(1'b0);
      wr_byte(VEC[v][18:11]);
      wr_byte(VEC[v][10:3]);
      wait_us(20);
      chk($sformatf("R7 R8 R11 R12 R13 vector %0d starts", v),
          {n_conv != c0, n_copy != c1, n_recall != c2}, VEC[v][2:0]);
      chk($sformatf("R11 R12 R13 vector %0d single pulse", v),
          (n_conv - c0) + (n_copy - c1) + (n_recall - c2), {61'd0, 3'(VEC[v][2] + VEC[v][1] + VEC[v][0])});
    end

    // R5 read identity
    bus_reset(1'b0);
    wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin rd_bit(b); got[i] = b; end
    chk("R5 identity", got, EXP_ID);
    chk("R5 family byte", got[7:0], 8'h28);
    rd_bit(b);
    chk("R5 silent after identity", b, 1'b1);

    // R6 R9 match then full scratchpad read
    bus_reset(1'b0);
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(EXP_ID[i]);
    wr_byte(8'hBE);
    for (int k = 0; k < 9; k++) begin
      rd_byte(by);
      chk($sformatf("R6 R9 scratch byte %0d", k), by, sp_byte(k));
    end
    rd_bit(b);
    chk("R9 silent after byte 8", b, 1'b1);

    // R6 mismatch
    bus_reset(1'b0);
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(i == 5 ? ~EXP_ID[i] : EXP_ID[i]);
    wr_byte(8'hBE);
    rd_byte(by);
    chk("R6 mismatch silent", by, 8'hFF);

    // R9 truncated read then restart
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'hBE);
    rd_byte(by); rd_byte(by);
    chk("R9 second byte", by, sp_byte(1));
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'hBE);
    rd_byte(by);
    chk("R9 restart from byte 0", by, sp_byte(0));

    // R10 R3 write scratchpad
    bus_reset(1'b0);
    c0 = n_wr;
    wr_byte(8'hCC); wr_byte(8'h4E);
    wr_byte(8'h5A); wr_byte(8'hC3); wr_byte(8'h7F);
    wait_us(10);
    chk("R10 three writes", n_wr - c0, 3);
    chk("R3 R10 byte order and bit order", {wr_log[0], wr_log[1], wr_log[2]}, 24'h5AC37F);
    chk("R10 indices", {wr_ilog[0], wr_ilog[1], wr_ilog[2]}, 6'b00_01_10);
    wr_byte(8'h11);
    wait_us(10);
    chk("R10 fourth byte ignored", n_wr - c0, 3);

    // R11 R4 conversion status
    conv_busy = 1'b1;
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'h44);
    rd_bit(b);
    chk("R11 busy reads 0", b, 1'b0);
    chk("R4 read-0 released by 40us", late_level, 1'b1);
    rd_bit(b);
    chk("R11 still busy", b, 1'b0);
    conv_busy = 1'b0;
    rd_bit(b);
    chk("R11 done reads 1", b, 1'b1);

    // R12 recall status
    recall_busy = 1'b1; conv_busy = 1'b1;
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'hB8);
    rd_bit(b);
    chk("R12 busy reads 0", b, 1'b0);
    recall_busy = 1'b0;
    rd_bit(b);
    chk("R12 done reads 1 despite conv busy", b, 1'b1);
    conv_busy = 1'b0;

    // R13 power mode
    parasite = 1'b1;
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'hB4);
    rd_bit(b);
    chk("R13 parasite reads 0", b, 1'b0);
    rd_bit(b);
    chk("R13 single answer", b, 1'b1);
    parasite = 1'b0;
    bus_reset(1'b0);
    wr_byte(8'hCC); wr_byte(8'hB4);
    rd_bit(b);
    chk("R13 external reads 1", b, 1'b1);

    // R2 abort during identity read, then a fresh transaction
    bus_reset(1'b0);
    wr_byte(8'h33);
    for (int i = 0; i < 10; i++) rd_bit(b);
    bus_reset(1'b1);
    c0 = n_conv;
    wr_byte(8'hCC); wr_byte(8'h44);
    wait_us(10);
    chk("R2 new transaction after abort", n_conv - c0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule